// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Arbiter

This block owns the status byte of a serial flash device and decides, one request at a time, whether a modify command handed over by the command decoder may proceed. A request carries an operation code, the sector it targets and, for a status write, a data byte. The block answers on the next cycle with a one-cycle `grant` or `refuse` pulse. A granted request raises the busy bit for a fixed, per-operation number of cycles. When that time runs out, the busy bit drops and the write-enable latch clears.

Protection has two layers. The software layer is the write-enable latch plus a three-bit protected-region field. The hardware layer is the register-lock bit combined with the external active-low protect pin: while the lock bit is set and the pin is low, status writes are refused. The status byte is presented continuously, so it can be read in any cycle, busy or not.

Operation codes on `req_op` are: 0 none, 1 enable-writes, 2 disable-writes, 3 program, 4 sector erase, 5 bulk erase, 6 status write, 7 reserved. The status byte layout is: bit 0 busy, bit 1 write-enable latch, bits 4:2 region field, bit 7 register lock, bits 6:5 always 0.

Top module: `flash_wp_unit`

## Requirements
- R1: After reset the status byte is 00h and neither `grant` nor `refuse` is high.
- R2: When not busy, enable-writes (code 1) sets status bit 1 and disable-writes (code 2) clears it, both visible in the cycle after the request.
- R3: A program, sector erase, bulk erase or status write (codes 3 to 6) is refused (`refuse` pulses, `grant` stays low) unless status bit 1 is set.
- R4: A granted request pulses `grant` and sets status bit 0 in the next cycle. Bit 0 stays high for exactly the operation's cycle count (8 program, 16 sector erase, 32 bulk erase, 4 status write by default). Bits 0 and 1 then fall together.
- R5: With region field k in 1..6, the top 2^(k-1) sectors (sector index 64 - 2^(k-1) up to 63) refuse program and sector erase. With k = 7, all 64 sectors refuse them. With k = 0, no sector refuses them.
- R6: Bulk erase is refused whenever the region field is non-zero.
- R7: A status write is refused while bit 7 is 1 and `wp_n` is 0. With `wp_n` high, it is accepted regardless of bit 7.
- R8: A status write copies data bits 7 and 4:2 into the status byte when its busy time ends, not before. Bits 6:5 always read 0, and data bits 1:0 have no effect.
- R9: While bit 0 is set, every modify request is refused and enable-writes and disable-writes leave bit 1 unchanged.
- R10: A refused request leaves bits 0 and 1 unchanged. Codes 0 and 7 produce neither pulse and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see above) |
| req_sector | input | 6 | Sector index targeted (byte address bits 21:16) |
| req_wdata | input | 8 | Data byte of a status write |
| wp_n | input | 1 | Active-low write-protect pin |
| status | output | 8 | Status byte, readable in any cycle |
| grant | output | 1 | One-cycle pulse: request accepted |
| refuse | output | 1 | One-cycle pulse: modify request rejected |

## Verification
Each verdict, the write-enable bit and the first busy cycle appear one clock after the edge that samples the request. The region and lock fields change only one clock after the last busy cycle. The bench drives every request on a falling edge, removes it on the next falling edge, and reads the outputs at that same falling edge, which is exactly one register stage later. Busy windows are measured by counting falling edges from the grant: bit 0 must still be high after the count minus one further edges, and low, together with bit 1, after one more.

// File: rtl/fwp_pkg.sv
// Shared definitions for the flash write-protect unit: operation codes and
// status-byte bit positions. Assumes a single request per cycle.
package fwp_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_WREN   = 3'd1,
        OP_WRDI   = 3'd2,
        OP_PROG   = 3'd3,
        OP_SERASE = 3'd4,
        OP_BERASE = 3'd5,
        OP_WRSR   = 3'd6,
        OP_RSVD   = 3'd7
    } fwp_op_e;

    localparam int SR_BUSY = 0;
    localparam int SR_WEL  = 1;
    localparam int SR_LOCK = 7;
    localparam logic [7:0] SR_WR_MASK = 8'h9C;
endpackage

// File: rtl/fwp_region_check.sv
// Decides whether a sector lies inside the region selected by the three-bit
// protect field. Field k (1..6) covers the top 2^(k-1) sectors, 7 covers all.
// Assumes SECTORS is a power of two no smaller than 32.
module fwp_region_check #(
    parameter int SECTORS = 64,
    parameter int SECT_W  = 6
) (
    input  logic [2:0]        bp,
    input  logic [SECT_W-1:0] sector,
    output logic              hit
);
    logic [SECT_W:0] span;
    logic [SECT_W:0] first;

    // Compare the sector against the lowest index of the protected region.
    always_comb begin
        span  = '0;
        first = '0;
        hit   = 1'b0;
        if (bp == 3'd7) begin
            hit = 1'b1;
        end else if (bp != 3'd0) begin
            span = (SECT_W+1)'(1) << (bp - 3'd1);
            if (span >= (SECT_W+1)'(SECTORS)) begin
                hit = 1'b1;
            end else begin
                first = (SECT_W+1)'(SECTORS) - span;
                hit   = ({1'b0, sector} >= first);
            end
        end
    end
endmodule

// File: rtl/fwp_accept_gate.sv
// Combinational verdict for one request: applies the write-enable latch,
// busy state, region hit, bulk rule and hardware lock. Assumes all inputs
// are registered state or stable request fields.
module fwp_accept_gate
    import fwp_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] op,
    input  logic       wel,
    input  logic       busy,
    input  logic       lock,
    input  logic       wp_n,
    input  logic       region_hit,
    input  logic       bp_any,
    output logic       accept,
    output logic       deny,
    output logic       set_wel,
    output logic       clr_wel
);
    logic is_mod;
    logic rule_ok;

    // Classify the request and apply the per-operation protection rule.
    always_comb begin
        is_mod  = 1'b0;
        rule_ok = 1'b0;
        case (fwp_op_e'(op))
            OP_PROG, OP_SERASE: begin is_mod = valid; rule_ok = !region_hit; end
            OP_BERASE:          begin is_mod = valid; rule_ok = !bp_any;     end
            OP_WRSR:            begin is_mod = valid; rule_ok = wp_n || !lock; end
            default:            begin is_mod = 1'b0;  rule_ok = 1'b0;        end
        endcase
        accept  = is_mod && wel && !busy && rule_ok;
        deny    = is_mod && !accept;
        set_wel = valid && (fwp_op_e'(op) == OP_WREN) && !busy;
        clr_wel = valid && (fwp_op_e'(op) == OP_WRDI) && !busy;
    end
endmodule

// File: rtl/fwp_busy_timer.sv
// Down-counter modelling the internal cycle time of a granted operation.
// expire is high in the last busy cycle. Assumes start only while idle.
module fwp_busy_timer #(
    parameter int MAXV  = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (start)          cnt <= load;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == CNT_W'(1));

    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAXV));
    p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt == '0));
endmodule

// File: rtl/flash_wp_unit.sv
// Flash status register and write-protect arbiter. Holds busy, write-enable,
// region and lock bits; grants or refuses modify requests and times the
// busy window. Assumes one request per cycle and a synchronous reset.
module flash_wp_unit
    import fwp_pkg::*;
#(
    parameter int SECTORS  = 64,
    parameter int T_PROG   = 8,
    parameter int T_SERASE = 16,
    parameter int T_BERASE = 32,
    parameter int T_WRSR   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [2:0]                   req_op,
    input  logic [$clog2(SECTORS)-1:0]   req_sector,
    input  logic [7:0]                   req_wdata,
    input  logic                         wp_n,
    output logic [7:0]                   status,
    output logic                         grant,
    output logic                         refuse
);
    localparam int SECT_W = $clog2(SECTORS);
    localparam int T_A    = (T_PROG > T_SERASE) ? T_PROG : T_SERASE;
    localparam int T_B    = (T_BERASE > T_WRSR) ? T_BERASE : T_WRSR;
    localparam int T_MAX  = (T_A > T_B) ? T_A : T_B;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    logic       busy_q, wel_q, lock_q, pend_wrsr_q, pend_lock_q;
    logic [2:0] bp_q, pend_bp_q;
    logic       region_hit, accept, deny, set_wel, clr_wel, expire;
    logic [CNT_W-1:0] load_val;

    fwp_region_check #(.SECTORS(SECTORS), .SECT_W(SECT_W)) u_region (
        .bp(bp_q), .sector(req_sector), .hit(region_hit)
    );

    fwp_accept_gate u_gate (
        .valid(req_valid), .op(req_op), .wel(wel_q), .busy(busy_q),
        .lock(lock_q), .wp_n(wp_n), .region_hit(region_hit),
        .bp_any(bp_q != 3'd0), .accept(accept), .deny(deny),
        .set_wel(set_wel), .clr_wel(clr_wel)
    );

    // Pick the busy duration of the requested operation.
    always_comb begin
        case (fwp_op_e'(req_op))
            OP_PROG:   load_val = CNT_W'(T_PROG);
            OP_SERASE: load_val = CNT_W'(T_SERASE);
            OP_BERASE: load_val = CNT_W'(T_BERASE);
            default:   load_val = CNT_W'(T_WRSR);
        endcase
    end

    fwp_busy_timer #(.MAXV(T_MAX), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(accept), .load(load_val), .expire(expire)
    );

    // Register the verdict pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant  <= 1'b0;
            refuse <= 1'b0;
        end else begin
            grant  <= accept;
            refuse <= deny;
        end
    end

    // Busy flag and pending status-write data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            pend_wrsr_q <= 1'b0;
            pend_bp_q   <= 3'd0;
            pend_lock_q <= 1'b0;
        end else if (accept) begin
            busy_q      <= 1'b1;
            pend_wrsr_q <= (fwp_op_e'(req_op) == OP_WRSR);
            pend_bp_q   <= req_wdata[4:2];
            pend_lock_q <= req_wdata[SR_LOCK];
        end else if (expire) begin
            busy_q      <= 1'b0;
            pend_wrsr_q <= 1'b0;
        end
    end

    // Write-enable latch: set/cleared by commands, cleared when a cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel_q <= 1'b0;
        else if (expire)  wel_q <= 1'b0;
        else if (set_wel) wel_q <= 1'b1;
        else if (clr_wel) wel_q <= 1'b0;
    end

    // Region and lock fields take the status-write data at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_q   <= 3'd0;
            lock_q <= 1'b0;
        end else if (expire && pend_wrsr_q) begin
            bp_q   <= pend_bp_q;
            lock_q <= pend_lock_q;
        end
    end

    assign status = {lock_q, 2'b00, bp_q, wel_q, busy_q};

    p_one_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && refuse));
    p_busy_from_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> grant);
    p_wel_drops_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> !wel_q);
    p_no_grant_in_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && $past(req_op == 3'd3 || req_op == 3'd4)) |-> $past(bp_q != 3'd7));
    p_bulk_needs_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && $past(req_op == 3'd5)) |-> $past(bp_q == 3'd0));
    p_hw_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && $past(req_op == 3'd6)) |-> $past(wp_n || !lock_q));
    p_wrsr_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && pend_wrsr_q) |->
        ({pend_lock_q, 2'b00, pend_bp_q, 2'b00} == ($past(req_wdata) & SR_WR_MASK)));
    p_busy_freezes_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> $stable(wel_q));
    p_refuse_keeps_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (refuse && !$fell(busy_q)) |-> ($stable(wel_q) && $stable(busy_q)));
endmodule

// File: tb/sim_flash_wp_unit.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_flash_wp_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [5:0] req_sector = 6'd0;
    logic [7:0] req_wdata = 8'd0;
    logic       wp_n = 1'b1;
    logic [7:0] status;
    logic       grant, refuse;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_wp_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_sector(req_sector), .req_wdata(req_wdata), .wp_n(wp_n),
        .status(status), .grant(grant), .refuse(refuse)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [5:0] sec, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_sector = sec; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
    endtask

    task automatic idle_wait();
        for (int i = 0; i < 64 && status[0]; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "status", status, 8'h00);
        chk("R1", "grant", grant, 0);
        chk("R1", "refuse", refuse, 0);
    endtask

    task automatic t_latch();
        issue(3'd1, 6'd0, 8'd0);
        chk("R2", "status after enable", status, 8'h02);
        issue(3'd2, 6'd0, 8'd0);
        chk("R2", "status after disable", status, 8'h00);
    endtask

    task automatic t_no_latch();
        issue(3'd3, 6'd0, 8'd0);
        chk("R3", "refuse", refuse, 1);
        chk("R3", "grant", grant, 0);
        chk("R10", "status", status, 8'h00);
    endtask

    task automatic t_program();
        issue(3'd1, 6'd0, 8'd0);
        issue(3'd3, 6'd0, 8'd0);
        chk("R4", "grant", grant, 1);
        chk("R4", "status first busy", status, 8'h03);
        repeat (7) @(negedge clk);
        chk("R4", "busy at cycle 8", status, 8'h03);
        @(negedge clk);
        chk("R4", "status after end", status, 8'h00);
    endtask

    task automatic t_busy();
        issue(3'd1, 6'd0, 8'd0);
        issue(3'd4, 6'd0, 8'd0);
        chk("R4", "erase grant", grant, 1);
        issue(3'd2, 6'd0, 8'd0);
        chk("R9", "disable ignored", status, 8'h03);
        issue(3'd3, 6'd1, 8'd0);
        chk("R9", "refuse while busy", refuse, 1);
        chk("R9", "status while busy", status, 8'h03);
        idle_wait();
        chk("R4", "status after erase", status, 8'h00);
    endtask

    task automatic t_wrsr_all();
        issue(3'd1, 6'd0, 8'd0);
        issue(3'd6, 6'd0, 8'hFF);
        chk("R8", "fields unchanged while busy", status, 8'h03);
        idle_wait();
        chk("R8", "status after write", status, 8'h9C);
        issue(3'd1, 6'd0, 8'd0);
        issue(3'd3, 6'd0, 8'd0);
        chk("R5", "program refused bp7", refuse, 1);
        issue(3'd4, 6'd63, 8'd0);
        chk("R5", "erase refused bp7", refuse, 1);
        issue(3'd5, 6'd0, 8'd0);
        chk("R6", "bulk refused", refuse, 1);
        chk("R10", "latch kept", status, 8'h9E);
    endtask

    task automatic t_hw_lock();
        wp_n = 1'b0;
        issue(3'd6, 6'd0, 8'h00);
        chk("R7", "refused when pin low", refuse, 1);
        chk("R7", "status", status, 8'h9E);
        wp_n = 1'b1;
        issue(3'd6, 6'd0, 8'h87);
        chk("R7", "accepted when pin high", grant, 1);
        idle_wait();
        chk("R8", "status 84", status, 8'h84);
    endtask

    task automatic t_regions();
        issue(3'd1, 6'd0, 8'd0);
        issue(3'd3, 6'd62, 8'd0);
        chk("R5", "sector 62 open at k=1", grant, 1);
        idle_wait();
        issue(3'd1, 6'd0, 8'd0);
        issue(3'd3, 6'd63, 8'd0);
        chk("R5", "sector 63 closed at k=1", refuse, 1);
        issue(3'd5, 6'd0, 8'd0);
        chk("R6", "bulk refused at k=1", refuse, 1);
        issue(3'd6, 6'd0, 8'h0C);
        chk("R7", "lock set pin high ok", grant, 1);
        idle_wait();
        chk("R8", "status 0C", status, 8'h0C);
        issue(3'd1, 6'd0, 8'd0);
        issue(3'd3, 6'd59, 8'd0);
        chk("R5", "sector 59 open at k=3", grant, 1);
        idle_wait();
        issue(3'd1, 6'd0, 8'd0);
        issue(3'd4, 6'd60, 8'd0);
        chk("R5", "sector 60 closed at k=3", refuse, 1);
        issue(3'd6, 6'd0, 8'h00);
        idle_wait();
        chk("R8", "fields cleared", status, 8'h00);
    endtask

    task automatic t_bulk();
        issue(3'd1, 6'd0, 8'd0);
        issue(3'd5, 6'd0, 8'd0);
        chk("R6", "bulk granted k=0", grant, 1);
        repeat (31) @(negedge clk);
        chk("R4", "bulk busy at 32", status, 8'h03);
        @(negedge clk);
        chk("R4", "bulk done", status, 8'h00);
    endtask

    task automatic t_ignored();
        issue(3'd1, 6'd0, 8'd0);
        issue(3'd7, 6'd0, 8'hFF);
        chk("R10", "code 7 pulses", {30'd0, grant, refuse}, 0);
        chk("R10", "code 7 status", status, 8'h02);
        issue(3'd0, 6'd0, 8'hFF);
        chk("R10", "code 0 status", status, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_no_latch();
        t_program();
        t_busy();
        t_wrsr_all();
        t_hw_lock();
        t_regions();
        t_bulk();
        t_ignored();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule